// File: doc/BRIEF.md
# Auto-Increment Windowed Memory Port

This block gives a host processor streaming access to a 32-bit, 1024-entry on-chip RAM through one register address. A write to the window address stores a word at the write index and advances that index. A read from the same address returns the word at the read index and advances the read index. The host may send a word as separate byte-strobed writes. The block gathers the lanes and commits the word only when all four lanes are present.

The storage is a RAM, not a plain first-in first-out queue. A second read port lets neighbouring logic read any entry at any time. The host also has a non-moving lookup path that returns the entry at an index it selects, which serves as a cross-check. A status register shows both indices and the number of bytes still waiting to be assembled.

The RAM reads synchronously. The word at the read index is therefore fetched ahead of time and refreshed every cycle, so that every lane of a popped word belongs to that word, even when reads come on consecutive cycles.

Top module: `wmp_window_port`

## Requirements
- R1: After synchronous reset, both indices are 0, no bytes are pending and `host_rdata` is 0.
- R2: A write to address 0 with all four strobes set and nothing pending stores the word at the write index and advances the index by one, in that single access.
- R3: Writes to address 0 with partial strobes replace the enabled byte lanes (strobe bit b covers bits 8b+7:8b) in an assembly buffer. A lane written twice keeps its latest byte. The word is stored and the write index advances when all four lanes have been written since the last store, and the buffer then empties. A write with no strobe bit set changes nothing.
- R4: A read of address 0 puts the word at the read index on `host_rdata` on the following cycle and advances the read index. This holds for reads on consecutive cycles and for a word stored in the cycle just before the read.
- R5: Both indices wrap from 1023 to 0.
- R6: A write to address 1 with bit 0 set clears both indices to 0. It leaves the assembly buffer alone. With bit 0 clear, the write has no effect.
- R7: A write to address 2 sets the lookup index from bits 9:0. A read of address 2 returns that index. A read of address 3 returns the entry at the lookup index, including a word stored on the previous cycle. Neither read moves an index.
- R8: A read of address 4 returns the write index in bits 9:0, the read index in bits 19:10 and the pending byte count in bits 22:20. All other bits read as 0.
- R9: `aux_rdata` shows, one cycle later, the entry at `aux_addr` as it stood before any store in that cycle. It is 0 after reset.
- R10: `host_rdata` holds its value on cycles without a host read. Reads of addresses 1 and 5 to 7 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_addr | input | 3 | Host register select (word address) |
| host_wdata | input | 32 | Host write data |
| host_wstrb | input | 4 | Byte-lane enables for host writes |
| host_wr | input | 1 | Host write request |
| host_rd | input | 1 | Host read request |
| host_rdata | output | 32 | Host read data, valid the cycle after `host_rd` |
| aux_addr | input | 10 | Random-access read index for other logic |
| aux_rdata | output | 32 | Random-access read data, one cycle latency |

## Verification
The hardest case to reach is a RAM read that collides with a store. The pop or lookup port must return a word stored one cycle earlier, and the auxiliary port must return the old contents in the same cycle as the store. The stimulus stores a word and pops it on the very next cycle, points the lookup index at the next write slot and reads it straight after the store, and freezes the auxiliary index on the slot being overwritten. A full 1024-word fill followed by 1024 back-to-back pops drives both indices through their wrap point. Assembly sequences that overwrite a lane, send an empty strobe and clear the indices mid-word check that partial words survive each of these events.

// File: rtl/wmp_pkg.sv
package wmp_pkg;

    localparam int DATA_W  = 32;
    localparam int BYTES   = DATA_W / 8;
    localparam int DEPTH   = 1024;
    localparam int PTR_W   = $clog2(DEPTH);
    localparam int HADDR_W = 3;
    localparam int CNT_W   = $clog2(BYTES + 1);

    typedef enum logic [HADDR_W-1:0] {
        SEL_WINDOW    = 3'd0,
        SEL_CTRL      = 3'd1,
        SEL_PEEK_IDX  = 3'd2,
        SEL_PEEK_DATA = 3'd3,
        SEL_STATUS    = 3'd4
    } reg_sel_e;

    typedef struct packed {
        logic     rd;
        logic     push;
        logic     pop;
        logic     clear;
        logic     set_idx;
        reg_sel_e sel;
    } host_op_t;

    function automatic host_op_t decode_host(
        input logic               wr,
        input logic               rd,
        input logic [HADDR_W-1:0] addr,
        input logic               clr_bit
    );
        host_op_t o;
        o.sel     = reg_sel_e'(addr);
        o.rd      = rd;
        o.push    = wr && (addr == SEL_WINDOW);
        o.pop     = rd && (addr == SEL_WINDOW);
        o.clear   = wr && (addr == SEL_CTRL) && clr_bit;
        o.set_idx = wr && (addr == SEL_PEEK_IDX);
        return o;
    endfunction

endpackage

// File: rtl/wmp_byte_merge.sv
module wmp_byte_merge
    import wmp_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           push,
    input  logic [W/8-1:0] strb,
    input  logic [W-1:0]   din,
    output logic           commit,
    output logic [W-1:0]   word,
    output logic [W/8-1:0] mask_o
);
    localparam int NB = W / 8;

    logic [W-1:0]  acc_q;
    logic [W-1:0]  merged;
    logic [NB-1:0] mask_q;
    logic [NB-1:0] mask_m;

    // each enabled lane replaces the buffered byte
    generate
        for (genvar b = 0; b < NB; b++) begin : g_lane
            assign merged[b*8 +: 8] = strb[b] ? din[b*8 +: 8] : acc_q[b*8 +: 8];
        end
    endgenerate

    assign mask_m = mask_q | strb;
    assign commit = push && (&mask_m);
    assign word   = merged;
    assign mask_o = mask_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q  <= '0;
            mask_q <= '0;
        end else if (push) begin
            if (&mask_m) begin
                acc_q  <= '0;
                mask_q <= '0;
            end else begin
                acc_q  <= merged;
                mask_q <= mask_m;
            end
        end
    end

endmodule

// File: rtl/wmp_ptr.sv
module wmp_ptr #(
    parameter int ENTRIES = 1024,
    parameter int W       = $clog2(ENTRIES)
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         adv,
    output logic [W-1:0] ptr_q,
    output logic [W-1:0] ptr_d
);
    localparam logic [W-1:0] LAST = W'(ENTRIES - 1);

    always_comb begin
        ptr_d = ptr_q;
        if (clr) begin
            ptr_d = '0;
        end else if (adv) begin
            ptr_d = (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) ptr_q <= '0;
        else     ptr_q <= ptr_d;
    end

endmodule

// File: rtl/wmp_ram.sv
module wmp_ram #(
    parameter int W       = 32,
    parameter int ENTRIES = 1024,
    parameter int AW      = $clog2(ENTRIES),
    parameter int NFWD    = 2
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     we,
    input  logic [AW-1:0]            waddr,
    input  logic [W-1:0]             wdata,
    input  logic [NFWD-1:0][AW-1:0]  fwd_addr,
    output logic [NFWD-1:0][W-1:0]   fwd_q,
    input  logic [AW-1:0]            aux_addr,
    output logic [W-1:0]             aux_q
);
    logic [W-1:0] mem [ENTRIES];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    // internal ports see a same-cycle store (write-first)
    always_ff @(posedge clk) begin
        for (int p = 0; p < NFWD; p++) begin
            fwd_q[p] <= (we && (waddr == fwd_addr[p])) ? wdata : mem[fwd_addr[p]];
        end
    end

    // outside port sees the contents before the store (read-first)
    always_ff @(posedge clk) begin
        if (rst) aux_q <= '0;
        else     aux_q <= mem[aux_addr];
    end

endmodule

// File: rtl/wmp_window_port.sv
module wmp_window_port
    import wmp_pkg::*;
#(
    parameter int WORD_W  = DATA_W,
    parameter int ENTRIES = DEPTH
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [HADDR_W-1:0]          host_addr,
    input  logic [WORD_W-1:0]           host_wdata,
    input  logic [WORD_W/8-1:0]         host_wstrb,
    input  logic                        host_wr,
    input  logic                        host_rd,
    output logic [WORD_W-1:0]           host_rdata,
    input  logic [$clog2(ENTRIES)-1:0]  aux_addr,
    output logic [WORD_W-1:0]           aux_rdata
);
    localparam int AW   = $clog2(ENTRIES);
    localparam int NB   = WORD_W / 8;
    localparam int PC_W = $clog2(NB + 1);

    host_op_t                 op;
    logic                     commit;
    logic [WORD_W-1:0]        commit_word;
    logic [NB-1:0]            asm_mask;
    logic [AW-1:0]            wr_ptr_q, wr_ptr_d;
    logic [AW-1:0]            rd_ptr_q, rd_ptr_d;
    logic [AW-1:0]            peek_idx_q, peek_idx_d;
    logic [1:0][AW-1:0]       fwd_addr;
    logic [1:0][WORD_W-1:0]   fwd_q;
    logic [PC_W-1:0]          pending;
    logic [WORD_W-1:0]        status_w;

    assign op = decode_host(host_wr, host_rd, host_addr, host_wdata[0]);

    wmp_byte_merge #(.W(WORD_W)) u_merge (
        .clk    (clk),
        .rst    (rst),
        .push   (op.push),
        .strb   (host_wstrb),
        .din    (host_wdata),
        .commit (commit),
        .word   (commit_word),
        .mask_o (asm_mask)
    );

    wmp_ptr #(.ENTRIES(ENTRIES), .W(AW)) u_wr_ptr (
        .clk   (clk),
        .rst   (rst),
        .clr   (op.clear),
        .adv   (commit),
        .ptr_q (wr_ptr_q),
        .ptr_d (wr_ptr_d)
    );

    wmp_ptr #(.ENTRIES(ENTRIES), .W(AW)) u_rd_ptr (
        .clk   (clk),
        .rst   (rst),
        .clr   (op.clear),
        .adv   (op.pop),
        .ptr_q (rd_ptr_q),
        .ptr_d (rd_ptr_d)
    );

    assign peek_idx_d = op.set_idx ? host_wdata[AW-1:0] : peek_idx_q;

    always_ff @(posedge clk) begin
        if (rst) peek_idx_q <= '0;
        else     peek_idx_q <= peek_idx_d;
    end

    // port 0 prefetches the pop word, port 1 tracks the lookup index
    assign fwd_addr[0] = rd_ptr_d;
    assign fwd_addr[1] = peek_idx_d;

    wmp_ram #(.W(WORD_W), .ENTRIES(ENTRIES), .AW(AW), .NFWD(2)) u_ram (
        .clk      (clk),
        .rst      (rst),
        .we       (commit),
        .waddr    (wr_ptr_q),
        .wdata    (commit_word),
        .fwd_addr (fwd_addr),
        .fwd_q    (fwd_q),
        .aux_addr (aux_addr),
        .aux_q    (aux_rdata)
    );

    always_comb begin
        pending = '0;
        for (int b = 0; b < NB; b++) begin
            pending = pending + PC_W'(asm_mask[b]);
        end
    end

    always_comb begin
        status_w = '0;
        status_w[AW-1:0]               = wr_ptr_q;
        status_w[2*AW-1:AW]            = rd_ptr_q;
        status_w[2*AW+PC_W-1:2*AW]     = pending;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            host_rdata <= '0;
        end else if (op.rd) begin
            case (op.sel)
                SEL_WINDOW:    host_rdata <= fwd_q[0];
                SEL_PEEK_IDX:  host_rdata <= WORD_W'(peek_idx_q);
                SEL_PEEK_DATA: host_rdata <= fwd_q[1];
                SEL_STATUS:    host_rdata <= status_w;
                default:       host_rdata <= '0;
            endcase
        end
    end

endmodule

// File: rtl/wmp_window_port_chk.sv
module wmp_window_port_chk
    import wmp_pkg::*;
#(
    parameter int NB = BYTES,
    parameter int AW = PTR_W
) (
    input logic          clk,
    input logic          rst,
    input host_op_t      op,
    input logic [NB-1:0] host_wstrb,
    input logic [AW-1:0] wr_ptr,
    input logic [AW-1:0] rd_ptr,
    input logic [NB-1:0] asm_mask
);
    // R2
    commit_full_word_chk: assert property (@(posedge clk) disable iff (rst)
        (op.push && host_wstrb == '1 && asm_mask == '0) |=> (wr_ptr == $past(wr_ptr) + 1'b1));

    // R3
    mask_never_full_chk: assert property (@(posedge clk) disable iff (rst)
        asm_mask != '1);

    // R3
    empty_strobe_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (op.push && host_wstrb == '0) |=> ($stable(asm_mask) && $stable(wr_ptr)));

    // R4
    rd_ptr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!op.pop && !op.clear) |=> $stable(rd_ptr));

    // R5
    rd_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (op.pop && rd_ptr == AW'(DEPTH - 1)) |=> (rd_ptr == '0));

    // R6
    clear_ptrs_chk: assert property (@(posedge clk) disable iff (rst)
        op.clear |=> (wr_ptr == '0 && rd_ptr == '0));

endmodule

bind wmp_window_port wmp_window_port_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .op         (op),
    .host_wstrb (host_wstrb),
    .wr_ptr     (wr_ptr_q),
    .rd_ptr     (rd_ptr_q),
    .asm_mask   (asm_mask)
);

// File: tb/tb_wmp_window_port.sv
module tb_wmp_window_port;

    localparam int ENT = 1024;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  host_addr  = '0;
    logic [31:0] host_wdata = '0;
    logic [3:0]  host_wstrb = '0;
    logic        host_wr    = 1'b0;
    logic        host_rd    = 1'b0;
    logic [31:0] host_rdata;
    logic [9:0]  aux_addr   = '0;
    logic [31:0] aux_rdata;

    always #5 clk = ~clk;

    wmp_window_port dut (
        .clk        (clk),
        .rst        (rst),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .host_wstrb (host_wstrb),
        .host_wr    (host_wr),
        .host_rd    (host_rd),
        .host_rdata (host_rdata),
        .aux_addr   (aux_addr),
        .aux_rdata  (aux_rdata)
    );

    int    vectors     = 0;
    int    miscompares = 0;
    bit    done        = 0;
    bit    aux_auto    = 1;
    string cur_req     = "R1";
    string lbl_q       = "R1";

    // behavioural reference model
    logic [31:0] m_mem [ENT];
    bit          m_val [ENT];
    int          m_wp = 0, m_rp = 0, m_pidx = 0;
    logic [31:0] m_adata = '0;
    logic [3:0]  m_amask = '0;
    logic [31:0] exp_rdata = '0;
    logic [31:0] exp_aux   = '0;
    bit          exp_aux_ok = 0;

    always @(posedge clk) begin
        int pend;
        logic [31:0] nd;
        logic [3:0]  nm;
        lbl_q = cur_req;
        if (rst) begin
            m_wp = 0; m_rp = 0; m_pidx = 0;
            m_adata = '0; m_amask = '0;
            exp_rdata = '0; exp_aux = '0; exp_aux_ok = 1;
        end else begin
            exp_aux_ok = m_val[aux_addr];
            exp_aux    = m_mem[aux_addr];
            pend = 0;
            for (int b = 0; b < 4; b++) if (m_amask[b]) pend++;
            if (host_rd) begin
                case (host_addr)
                    3'd0: begin exp_rdata = m_mem[m_rp]; m_rp = (m_rp + 1) % ENT; end
                    3'd2: exp_rdata = 32'(m_pidx);
                    3'd3: exp_rdata = m_mem[m_pidx];
                    3'd4: exp_rdata = 32'((pend << 20) | (m_rp << 10) | m_wp);
                    default: exp_rdata = '0;
                endcase
            end
            if (host_wr) begin
                case (host_addr)
                    3'd0: begin
                        nd = m_adata; nm = m_amask | host_wstrb;
                        for (int b = 0; b < 4; b++)
                            if (host_wstrb[b]) nd[b*8 +: 8] = host_wdata[b*8 +: 8];
                        if (nm == 4'hF) begin
                            m_mem[m_wp] = nd; m_val[m_wp] = 1;
                            m_wp = (m_wp + 1) % ENT;
                            m_adata = '0; m_amask = '0;
                        end else begin
                            m_adata = nd; m_amask = nm;
                        end
                    end
                    3'd1: if (host_wdata[0]) begin m_wp = 0; m_rp = 0; end
                    3'd2: m_pidx = int'(host_wdata[9:0]);
                    default: ;
                endcase
            end
        end
    end

    // compare every cycle, away from the active edge
    always @(negedge clk) begin
        if (!done) begin
            vectors++;
            if (host_rdata !== exp_rdata) begin
                miscompares++;
                $display("FAIL %s host_rdata actual %h expected %h", lbl_q, host_rdata, exp_rdata);
            end
            if (exp_aux_ok) begin
                vectors++;
                if (aux_rdata !== exp_aux) begin
                    miscompares++;
                    $display("FAIL R9 aux_rdata actual %h expected %h", aux_rdata, exp_aux);
                end
            end
            if (aux_auto) aux_addr <= aux_addr + 10'd37;
        end
    end

    task automatic wr(input logic [2:0] a, input logic [31:0] d, input logic [3:0] s);
        host_addr = a; host_wdata = d; host_wstrb = s; host_wr = 1'b1;
        @(posedge clk); @(negedge clk);
        host_wr = 1'b0; host_wstrb = '0;
    endtask

    task automatic rd(input logic [2:0] a);
        host_addr = a; host_rd = 1'b1;
        @(posedge clk); @(negedge clk);
        host_rd = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [31:0] pat(input int i);
        return (32'(i) * 32'h9E3779B1) ^ 32'hA5A5A5A5;
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset status
        cur_req = "R1";  rd(3'd4);
        // R10: unmapped reads and holding
        cur_req = "R10"; rd(3'd7); rd(3'd1); idle(3);

        // R2 then R4: full word, popped on the very next cycle
        cur_req = "R2"; wr(3'd0, 32'hA5A5A5A5, 4'hF);
        cur_req = "R4"; rd(3'd0);
        cur_req = "R2"; wr(3'd0, 32'h5A5A5A5A, 4'hF);
        cur_req = "R4"; rd(3'd0);

        // R3: byte assembly, lane overwrite, empty strobe
        cur_req = "R3";
        wr(3'd0, 32'h0000_0011, 4'b0001);
        rd(3'd4);
        wr(3'd0, 32'h0000_2200, 4'b0010);
        wr(3'd0, 32'h0000_3300, 4'b0010);
        wr(3'd0, 32'hFFFF_FFFF, 4'b0000);
        rd(3'd4);
        wr(3'd0, 32'h4400_0000, 4'b1000);
        wr(3'd0, 32'h0055_0000, 4'b0100);
        rd(3'd4);
        rd(3'd0);
        wr(3'd0, 32'h0000_BEEF, 4'b0011);
        wr(3'd0, 32'hDEAD_0000, 4'b1100);
        rd(3'd0);

        // R6: clear ignores bit0 = 0, keeps a pending lane
        cur_req = "R6";
        wr(3'd0, 32'h0000_0077, 4'b0001);
        wr(3'd1, 32'h0000_0000, 4'hF);
        rd(3'd4);
        wr(3'd1, 32'h0000_0001, 4'hF);
        rd(3'd4);
        wr(3'd0, 32'h1234_5600, 4'b1110);
        rd(3'd0);
        rd(3'd4);

        // R5/R4: fill all entries, then back-to-back pops, both wrap
        cur_req = "R5";
        wr(3'd1, 32'h1, 4'hF);
        for (int i = 0; i < ENT; i++) wr(3'd0, pat(i), 4'hF);
        rd(3'd4);
        cur_req = "R4";
        for (int i = 0; i < ENT; i++) rd(3'd0);
        cur_req = "R5";
        rd(3'd4);
        wr(3'd0, 32'hCAFE_F00D, 4'hF);
        rd(3'd0);
        rd(3'd4);

        // R9: outside port reads old contents during a store
        cur_req = "R9";
        aux_auto = 0;
        wr(3'd1, 32'h1, 4'hF);
        aux_addr = 10'd0;
        idle(1);
        wr(3'd0, 32'h0BAD_BEEF, 4'hF);
        idle(2);
        aux_addr = 10'd1023;
        idle(2);
        aux_auto = 1;

        // R7: lookup path, including a freshly stored entry
        cur_req = "R7";
        wr(3'd2, 32'd0, 4'hF);
        rd(3'd2);
        rd(3'd3);
        wr(3'd2, 32'd1023, 4'hF);
        rd(3'd3);
        wr(3'd2, 32'd1, 4'hF);
        wr(3'd0, 32'h7E57_1DEA, 4'hF);
        rd(3'd3);
        rd(3'd2);
        // R8: peeks moved no index
        cur_req = "R8";
        rd(3'd4);
        idle(4);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            miscompares++;
            $display("FAIL watchdog run did not complete");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

endmodule